// File: doc/BRIEF.md
# Stop-Mode Recovery Sequencer

This block decides when a processor core may run again after a low-power stop. A one-cycle stop request takes it from running to stopped. At that moment it captures four configuration bits: clock source (internal oscillator or external clock), PLL in use, clock kept alive during stop, and short stabilization delay. While stopped it gates the oscillator and PLL enables according to those captured bits. A wake event (interrupt or reset request) starts recovery.

During recovery a stabilization delay counter and a PLL relock wait run at the same time. The core is released only when the later of the two has finished. The counter length is long, short or minimal, depending on the captured bits. The relock wait follows the lock input rather than a fixed count, because relock may take anywhere from 0 to about 1000 cycles. The relock wait applies only when the PLL was switched off during stop.

Top module: `stop_recovery_seq`

## Requirements
- R1: An asynchronous active-low reset, applied in any state, brings the block to the running state with `osc_en`, `pll_en` and `core_run` all high.
- R2: A `stop_req` pulse sampled while running drops `core_run` in the next cycle and captures the four configuration bits.
- R3: While stopped, `osc_en` is low only if the internal oscillator is selected (`cfg_ext_clk`=0) and `cfg_keep_clk`=0. `pll_en` is low only if `cfg_pll_on`=1 and `cfg_keep_clk`=0. Otherwise each enable stays high.
- R4: The stopped state is held until `wake` is sampled high. `wake` has no effect while running.
- R5: With `cfg_keep_clk`=1, `core_run` rises MIN_DLY clock edges after the edge that samples `wake`, whatever the values of `cfg_short_dly` and `cfg_ext_clk`.
- R6: With `cfg_keep_clk`=0, the delay is SHORT_DLY edges if `cfg_short_dly`=1 and LONG_DLY edges if it is 0, for either clock source.
- R7: With `cfg_pll_on`=1 and `cfg_keep_clk`=0, `pll_locked` must also be seen high during recovery. If it first appears in recovery cycle c+1 (c edges after the wake edge), `core_run` rises max(delay, c+1) edges after the wake edge.
- R8: When the relock wait does not apply, `pll_locked` is ignored and only the delay counter gates the release.
- R9: During recovery, `wake`, `stop_req` and changes to the configuration inputs have no effect. Configuration changes while stopped also have no effect.
- R10: During recovery, `osc_en` and `pll_en` are high. After release the block returns to running with `core_run` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to enter stop |
| wake | input | 1 | Wake event that starts recovery |
| cfg_ext_clk | input | 1 | 1 = external clock, 0 = internal oscillator |
| cfg_pll_on | input | 1 | PLL in use |
| cfg_keep_clk | input | 1 | Clock and PLL stay alive during stop |
| cfg_short_dly | input | 1 | Use the short stabilization delay |
| pll_locked | input | 1 | PLL lock indication |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_run | output | 1 | Core may execute |

## Verification
The bench builds the block with LONG_DLY=40, SHORT_DLY=6 and MIN_DLY=2. This keeps the full-length stabilization path short enough to measure exactly, cycle by cycle, across many configurations. Because the short delay is small, lock arrival times of 0, 3, 5, 6 and 20 cycles fall on both sides of the counter's end, so each side of the "later of the two" rule is the deciding one in some case. The boundary where lock arrives exactly at the counter's last cycle is also reached.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_RECOVER = 2'd2,
        ST_DONE    = 2'd3
    } srs_state_e;

    typedef struct packed {
        logic ext_clk;
        logic pll_on;
        logic keep_clk;
        logic short_dly;
    } srs_cfg_t;
endpackage

// File: rtl/srs_delay_counter.sv
module srs_delay_counter #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/srs_lock_wait.sv
module srs_lock_wait (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    input  logic need,
    input  logic pll_locked,
    output logic ready
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (clear)
            seen_d = 1'b0;
        else if (arm && pll_locked)
            seen_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    assign ready = !need || seen_q || (arm && pll_locked);

    // R8
    no_need_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !need |-> ready);
endmodule

// File: rtl/stop_recovery_seq.sv
module stop_recovery_seq #(
    parameter int LONG_DLY  = 131072,
    parameter int SHORT_DLY = 16,
    parameter int MIN_DLY   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake,
    input  logic cfg_ext_clk,
    input  logic cfg_pll_on,
    input  logic cfg_keep_clk,
    input  logic cfg_short_dly,
    input  logic pll_locked,
    output logic osc_en,
    output logic pll_en,
    output logic core_run
);
    import srs_pkg::*;

    localparam int CW = $clog2(LONG_DLY + 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_DLY - 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_DLY - 1);
    localparam logic [CW-1:0] MIN_LD   = CW'(MIN_DLY - 1);

    typedef struct packed {
        srs_state_e state;
        srs_cfg_t   cfg;
    } seq_t;

    seq_t s_d, s_q;

    logic          dly_load;
    logic [CW-1:0] dly_val;
    logic          dly_expired;
    logic          lock_need;
    logic          lock_ready;
    logic          in_recover;

    assign in_recover = (s_q.state == ST_RECOVER);
    assign lock_need  = s_q.cfg.pll_on && !s_q.cfg.keep_clk;

    always_comb begin
        s_d      = s_q;
        dly_load = 1'b0;
        if (s_q.cfg.keep_clk)       dly_val = MIN_LD;
        else if (s_q.cfg.short_dly) dly_val = SHORT_LD;
        else                        dly_val = LONG_LD;

        case (s_q.state)
            ST_RUN: begin
                if (stop_req) begin
                    s_d.state = ST_STOPPED;
                    s_d.cfg   = '{ext_clk: cfg_ext_clk, pll_on: cfg_pll_on,
                                  keep_clk: cfg_keep_clk, short_dly: cfg_short_dly};
                end
            end
            ST_STOPPED: begin
                if (wake) begin
                    s_d.state = ST_RECOVER;
                    dly_load  = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (dly_expired && lock_ready)
                    s_d.state = ST_DONE;
            end
            default: s_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_RUN, cfg: '0};
        else        s_q <= s_d;
    end

    srs_delay_counter #(.CW(CW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .expired  (dly_expired)
    );

    srs_lock_wait u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (dly_load),
        .arm        (in_recover),
        .need       (lock_need),
        .pll_locked (pll_locked),
        .ready      (lock_ready)
    );

    always_comb begin
        osc_en   = 1'b1;
        pll_en   = 1'b1;
        core_run = (s_q.state == ST_RUN) || (s_q.state == ST_DONE);
        if (s_q.state == ST_STOPPED) begin
            osc_en = s_q.cfg.ext_clk || s_q.cfg.keep_clk;
            pll_en = !s_q.cfg.pll_on || s_q.cfg.keep_clk;
        end
    end

    // R2
    stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN && stop_req) |=> !core_run);

    // R4
    stay_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_STOPPED && !wake) |=> (s_q.state == ST_STOPPED));

    // R7
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recover && !lock_ready) |=> !core_run);

    // R9
    hold_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recover && !dly_expired) |=> in_recover);

    // R10
    recover_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_recover |-> (osc_en && pll_en && !core_run));

    // R3
    keep_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_STOPPED && s_q.cfg.keep_clk) |-> (osc_en && pll_en));
endmodule

// File: tb/sim_stop_recovery_seq.sv
`timescale 1ns/100ps
module sim_stop_recovery_seq;
    localparam int LONG_DLY  = 40;
    localparam int SHORT_DLY = 6;
    localparam int MIN_DLY   = 2;
    localparam int NV = 13;

    // cfg nibble = {ext_clk, pll_on, keep_clk, short_dly}
    localparam int V_CFG [NV] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1001,
                                  4'b1000, 4'b1011, 4'b0101, 4'b0100, 4'b1101,
                                  4'b1101, 4'b0110, 4'b0101};
    localparam int V_LOCK[NV] = '{-1, -1, -1, -1, -1, -1, -1, 20, 3, 5, 6, -1, 0};
    localparam int V_OSC [NV] = '{0, 0, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 0};
    localparam int V_PLL [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 0};
    localparam int V_LAT [NV] = '{40, 6, 2, 2, 6, 40, 2, 21, 40, 6, 7, 2, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, wake = 1'b0;
    logic cfg_ext_clk = 1'b0, cfg_pll_on = 1'b0, cfg_keep_clk = 1'b0, cfg_short_dly = 1'b0;
    logic pll_locked = 1'b0;
    logic osc_en, pll_en, core_run;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    stop_recovery_seq #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY), .MIN_DLY(MIN_DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
        .cfg_ext_clk(cfg_ext_clk), .cfg_pll_on(cfg_pll_on),
        .cfg_keep_clk(cfg_keep_clk), .cfg_short_dly(cfg_short_dly),
        .pll_locked(pll_locked), .osc_en(osc_en), .pll_en(pll_en), .core_run(core_run)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int c);
        cfg_ext_clk   = c[3];
        cfg_pll_on    = c[2];
        cfg_keep_clk  = c[1];
        cfg_short_dly = c[0];
    endtask

    task automatic do_stop();
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
    endtask

    task automatic do_wake();
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
    endtask

    // counts edges after the wake edge until core_run is high
    task automatic run_recovery(input int lock_at, input bit glitch, output int lat);
        lat = -1;
        for (int n = 0; n < 300; n++) begin
            pll_locked = (lock_at >= 0) && (n >= lock_at);
            wake       = glitch && (n == 2);
            stop_req   = glitch && (n == 3);
            if (glitch && n == 1) set_cfg(4'b0010);
            if (core_run) begin
                lat = n;
                break;
            end
            @(negedge clk);
        end
        wake = 1'b0;
        stop_req = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        string tag;
        #12;
        // R1: reset state
        check(osc_en && pll_en && core_run, "R1", {osc_en, pll_en, core_run}, 7);
        @(negedge clk) rst_n = 1'b1;

        // R4: wake while running is ignored
        do_wake();
        check(core_run && osc_en && pll_en, "R4", {osc_en, pll_en, core_run}, 7);

        // vector table
        for (int i = 0; i < NV; i++) begin
            set_cfg(V_CFG[i]);
            pll_locked = 1'b0;
            do_stop();
            check(!core_run, "R2", core_run, 0);
            check(osc_en == V_OSC[i][0], "R3", osc_en, V_OSC[i]);
            check(pll_en == V_PLL[i][0], "R3", pll_en, V_PLL[i]);
            do_wake();
            check(osc_en && pll_en && !core_run, "R10", {osc_en, pll_en, core_run}, 6);
            run_recovery(V_LOCK[i], 1'b0, lat);
            if (V_CFG[i][1])      tag = "R5";
            else if (V_CFG[i][2]) tag = "R7";
            else                  tag = "R6";
            check(lat == V_LAT[i], tag, lat, V_LAT[i]);
            @(negedge clk);
            pll_locked = 1'b0;
            @(negedge clk);
            check(core_run && osc_en && pll_en, "R10", {osc_en, pll_en, core_run}, 7);
        end

        // R4: stopped held without wake
        set_cfg(4'b0001);
        do_stop();
        repeat (6) @(negedge clk);
        check(!core_run && !osc_en, "R4", {osc_en, core_run}, 0);
        // R9: config change while stopped ignored
        set_cfg(4'b1010);
        @(negedge clk);
        check(!osc_en, "R9", osc_en, 0);
        do_wake();
        run_recovery(-1, 1'b1, lat);
        check(lat == SHORT_DLY, "R9", lat, SHORT_DLY);
        @(negedge clk);

        // R8: PLL off, lock never seen, long delay
        set_cfg(4'b0000);
        pll_locked = 1'b0;
        do_stop();
        check(pll_en, "R8", pll_en, 1);
        do_wake();
        run_recovery(-1, 1'b0, lat);
        check(lat == LONG_DLY, "R8", lat, LONG_DLY);
        @(negedge clk);

        // R1: reset while stopped
        set_cfg(4'b0100);
        do_stop();
        check(!osc_en && !pll_en, "R3", {osc_en, pll_en}, 0);
        @(negedge clk) rst_n = 1'b0;
        #1;
        check(osc_en && pll_en && core_run, "R1", {osc_en, pll_en, core_run}, 7);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(core_run, "R1", core_run, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule